// File: doc/BRIEF.md
# Modem Status Line Monitor

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, data-carrier-detect and ring indicator. Each pin is first brought into the system clock domain through a flop chain. It then passes a small agreement filter, and that filter only takes a sample on cycles where the twice-baud-rate tick from the baud generator is high. The filtered levels go into an 8-bit status word.

Changes of the filtered levels set sticky flags. Three of the lines flag any change. The ring line flags only the end of a ring, when its filtered pin goes from low back to high. A read strobe from the register decode clears the flags, and a modem-status interrupt request is raised while any flag is set. The baud generator, the register decode and the interrupt priority logic live outside this block.

Top module: `modem_status_monitor`

## Requirements
- R1: After reset, with all four pins high (inactive), `status_q` is 8'h00 and `irq` is 0.
- R2: Each pin passes through `SYNC_STAGES` (default 2) clock flops before the filter sees it. With the tick high on every cycle, a pin change driven just after clock edge E0 shows in `status_q[7:4]` after edge E4 and not before.
- R3: The filter samples only on cycles where `tick2x` is high. Without ticks, `status_q[7:4]` holds its value whatever the pins do.
- R4: A filtered level takes a new value only once `FILT_DEPTH` (default 2) consecutive tick samples agree on it. A pulse that is seen by fewer ticks changes neither the level nor any flag.
- R5: `status_q[7:4]` holds the inverted filtered pin levels: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring, bit 7 carrier-detect. A pin held low reads as 1.
- R6: Bit 0 (clear-to-send change), bit 1 (data-set-ready change) and bit 3 (carrier-detect change) are set one cycle after their filtered level changes in either direction.
- R7: Bit 2 (ring ended) is set one cycle after status bit 6 falls from 1 to 0. It is not set when bit 6 rises.
- R8: When `status_rd` is high in a cycle, bits 3:0 are cleared at the next clock edge.
- R9: If a flag's setting event and `status_rd` fall in the same cycle, the flag is set, so the event is not lost.
- R10: `irq` is high exactly while at least one of `status_q[3:0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick2x | input | 1 | Twice-baud-rate sample enable, one cycle wide |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low, asynchronous |
| ri_n_pin | input | 1 | Ring indicator pin, active low, asynchronous |
| status_rd | input | 1 | Status word read strobe; clears the change flags |
| status_q | output | 8 | Change flags in bits 3:0, inverted filtered levels in bits 7:4 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A wrong filter history or a wrong synchronizer stage shows up as a level bit in `status_q[7:4]` that moves one or more cycles too early or too late. The bench compares the status word on every cycle against a behavioural model, so such an error is caught within the cycle the level should have moved. A stale or lost change flag shows in `status_q[3:0]` and in `irq` one cycle after the filtered edge, or one cycle after a read. Directed sequences put a read on exactly the setting cycle and hold the ring line in both directions, so an error in priority or in edge polarity is visible at once.

// File: rtl/msm_pkg.sv
package msm_pkg;
   localparam int LINES = 4;

   // Internal line index; equals the position inside each status nibble.
   typedef enum int {
      LN_CTS = 0,
      LN_DSR = 1,
      LN_RI  = 2,
      LN_DCD = 3
   } line_e;

   // Lines whose flag marks only the end of an assertion (filtered pin rising).
   localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;

   function automatic logic [2*LINES-1:0] pack_status(input logic [LINES-1:0] lvl_n,
                                                      input logic [LINES-1:0] flags);
      return {~lvl_n, flags};
   endfunction
endpackage

// File: rtl/msm_sync.sv
module msm_sync #(
   parameter int WIDTH     = 4,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 1) begin : g_bad_stages
      $error("msm_sync: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("msm_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= {WIDTH{RESET_VAL}};
      end else begin
         chain[0] <= d_async;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= {WIDTH{RESET_VAL}};
         end else begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/msm_glitch_filter.sv
module msm_glitch_filter #(
   parameter int DEPTH     = 2,
   parameter bit RESET_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic din,
   output logic dout
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("msm_glitch_filter: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_direct
      // A single sample is enough: follow the input on every tick.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout <= RESET_LVL;
         end else if (sample_en) begin
            dout <= din;
         end
      end
   end else begin : g_vote
      localparam int HIST = DEPTH - 1;
      logic [HIST-1:0]  hist;
      logic [DEPTH-1:0] window;
      logic             all_hi;
      logic             all_lo;

      assign window = {hist, din};
      assign all_hi = &window;
      assign all_lo = ~(|window);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist <= {HIST{RESET_LVL}};
            dout <= RESET_LVL;
         end else if (sample_en) begin
            hist <= window[HIST-1:0];
            if (all_hi) begin
               dout <= 1'b1;
            end else if (all_lo) begin
               dout <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/msm_change_flags.sv
module msm_change_flags #(
   parameter int           N         = 4,
   parameter logic [N-1:0] TRAIL     = '0,
   parameter bit           RESET_LVL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_n,
   input  logic         clr,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("msm_change_flags: N must be at least 1");
   end

   logic [N-1:0] lvl_n_d;
   logic [N-1:0] event_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_n_d <= {N{RESET_LVL}};
      end else begin
         lvl_n_d <= lvl_n;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      if (TRAIL[i]) begin : g_trail
         // Pin returning high: the line has just been released.
         assign event_hit[i] = ~lvl_n_d[i] & lvl_n[i];
      end else begin : g_any
         assign event_hit[i] = lvl_n_d[i] ^ lvl_n[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
         end else if (event_hit[i]) begin
            flags[i] <= 1'b1;
         end else if (clr) begin
            flags[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick2x,
   input  logic       cts_n_pin,
   input  logic       dsr_n_pin,
   input  logic       dcd_n_pin,
   input  logic       ri_n_pin,
   input  logic       status_rd,
   output logic [7:0] status_q,
   output logic       irq
);
   import msm_pkg::*;

   localparam int SW = 2 * LINES;

   if (SW != 8) begin : g_bad_lines
      $error("modem_status_monitor: status word must be 8 bits");
   end

   logic [LINES-1:0] pins_n;
   logic [LINES-1:0] sync_n;
   logic [LINES-1:0] filt_n;
   logic [LINES-1:0] flags;

   always_comb begin
      pins_n         = '0;
      pins_n[LN_CTS] = cts_n_pin;
      pins_n[LN_DSR] = dsr_n_pin;
      pins_n[LN_RI]  = ri_n_pin;
      pins_n[LN_DCD] = dcd_n_pin;
   end

   msm_sync #(
      .WIDTH     (LINES),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_n),
      .q_sync  (sync_n)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_filt
      msm_glitch_filter #(
         .DEPTH     (FILT_DEPTH),
         .RESET_LVL (1'b1)
      ) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample_en (tick2x),
         .din       (sync_n[l]),
         .dout      (filt_n[l])
      );
   end

   msm_change_flags #(
      .N         (LINES),
      .TRAIL     (TRAIL_ONLY),
      .RESET_LVL (1'b1)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_n   (filt_n),
      .clr     (status_rd),
      .flags   (flags)
   );

   assign status_q = pack_status(filt_n, flags);
   assign irq      = |flags;
endmodule

// File: rtl/msm_checker.sv
module msm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tick2x,
   input logic       status_rd,
   input logic [7:0] status_q,
   input logic       irq
);
   // R3: no tick, no movement of the level nibble
   p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick2x |=> $stable(status_q[7:4]));

   // R6: a level change is followed by its change flag
   p_cts_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_q[4]) |=> status_q[0]);
   p_dsr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_q[5]) |=> status_q[1]);
   p_dcd_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_q[7]) |=> status_q[3]);

   // R7: ring-ended flag only rises after the ring level fell
   p_ring_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[2]) |-> ($past(status_q[6], 2) && !$past(status_q[6])));

   // R8: a flag stays set until a read
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[0] && !status_rd) |=> status_q[0]);

   // R8: a read with no new change clears the flag
   p_cts_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && $stable(status_q[4])) |=> !status_q[0]);

   // R9: a change in the reading cycle still leaves the flag set
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !$stable(status_q[5])) |=> status_q[1]);

   // R10: request tracks the flags
   p_irq_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (status_q[3:0] != 4'h0));
endmodule

bind modem_status_monitor msm_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick2x    (tick2x),
   .status_rd (status_rd),
   .status_q  (status_q),
   .irq       (irq)
);

// File: tb/modem_status_monitor_tb.sv
module modem_status_monitor_tb;
   localparam int SYNC  = 2;
   localparam int DEPTH = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick2x = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
   logic       status_rd = 1'b0;
   logic [7:0] status_q;
   logic       irq;

   int errors = 0;
   int checks = 0;
   int tick_mode = 0;   // 0 none, 1 every cycle, 2 every fourth, 3 random
   int tick_cnt = 0;
   bit model_on = 1'b1;
   bit done = 1'b0;

   always #5 clk = ~clk;

   modem_status_monitor #(.SYNC_STAGES(SYNC), .FILT_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick2x(tick2x),
      .cts_n_pin(cts_n), .dsr_n_pin(dsr_n), .dcd_n_pin(dcd_n), .ri_n_pin(ri_n),
      .status_rd(status_rd), .status_q(status_q), .irq(irq));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Tick generator, changes just after each edge
   always @(posedge clk) begin
      #1;
      tick_cnt++;
      case (tick_mode)
         1: tick2x = 1'b1;
         2: tick2x = (tick_cnt % 4) == 0;
         3: tick2x = ($urandom % 3) == 0;
         default: tick2x = 1'b0;
      endcase
   end

   // Behavioural reference: delay queue, run-length vote, edge flags
   logic m_pipe [4][$];
   int   m_run [4];
   logic m_runv [4];
   logic m_lvl [4];
   logic m_lvl_old [4];
   logic m_flag [4];

   function automatic logic pin_of(input int l);
      case (l)
         0: return cts_n;
         1: return dsr_n;
         2: return ri_n;
         default: return dcd_n;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < 4; l++) begin
            m_pipe[l].delete();
            for (int s = 0; s < SYNC; s++) m_pipe[l].push_back(1'b1);
            m_run[l] = DEPTH; m_runv[l] = 1'b1;
            m_lvl[l] = 1'b1; m_lvl_old[l] = 1'b1; m_flag[l] = 1'b0;
         end
      end else begin
         for (int l = 0; l < 4; l++) begin
            logic ev;
            logic smp;
            ev = (l == 2) ? (!m_lvl_old[l] && m_lvl[l]) : (m_lvl_old[l] != m_lvl[l]);
            if (ev) m_flag[l] = 1'b1;
            else if (status_rd) m_flag[l] = 1'b0;
            m_lvl_old[l] = m_lvl[l];
            smp = m_pipe[l][0];
            if (tick2x) begin
               if (smp == m_runv[l]) begin
                  if (m_run[l] < DEPTH) m_run[l]++;
               end else begin
                  m_runv[l] = smp; m_run[l] = 1;
               end
               if (m_run[l] >= DEPTH) m_lvl[l] = m_runv[l];
            end
            void'(m_pipe[l].pop_front());
            m_pipe[l].push_back(pin_of(l));
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         logic [7:0] e;
         e = {~m_lvl[3], ~m_lvl[2], ~m_lvl[1], ~m_lvl[0],
              m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
         chk("R5 R2 R3 R4 levels", {4'h0, status_q[7:4]}, {4'h0, e[7:4]});
         chk("R6 R8 R9 change flags", {5'h0, status_q[3], status_q[1:0]}, {5'h0, e[3], e[1:0]});
         chk("R7 ring-ended flag", {7'h0, status_q[2]}, {7'h0, e[2]});
         chk("R10 irq", {7'h0, irq}, {7'h0, (e[3:0] != 4'h0)});
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      @(negedge clk);
      chk("R1 reset status", status_q, 8'h00);
      chk("R1 reset irq", {7'h0, irq}, 8'h00);

      // R3: no ticks, pin moves, nothing changes
      step(1);
      dcd_n = 1'b0;
      step(20);
      @(negedge clk);
      chk("R3 no tick hold", status_q, 8'h00);

      // R2 R4: tick every cycle, exact latency of the level
      dcd_n = 1'b1;
      step(1);
      tick_mode = 1;
      step(8);
      cts_n = 1'b0;                     // driven after E0
      step(3);                          // after E3
      @(negedge clk);
      chk("R2 level not yet", {7'h0, status_q[4]}, 8'h00);
      step(1);                          // after E4, in read cycle for E5
      status_rd = 1'b1;
      @(negedge clk);
      chk("R2 level after four edges", {7'h0, status_q[4]}, 8'h01);
      step(1);
      status_rd = 1'b0;
      @(negedge clk);
      chk("R9 set wins over read", {7'h0, status_q[0]}, 8'h01);
      step(1);
      status_rd = 1'b1;
      step(1);
      status_rd = 1'b0;
      @(negedge clk);
      chk("R8 read clears flag", {7'h0, status_q[0]}, 8'h00);
      chk("R10 irq low after clear", {7'h0, irq}, 8'h00);

      // R7: ring asserted does not set the flag; its release does
      step(1);
      ri_n = 1'b0;
      step(10);
      @(negedge clk);
      chk("R7 ring start no flag", {6'h0, status_q[6], status_q[2]}, 8'h02);
      step(1);
      ri_n = 1'b1;
      step(10);
      @(negedge clk);
      chk("R7 ring end flag", {6'h0, status_q[6], status_q[2]}, 8'h01);
      chk("R10 irq from ring end", {7'h0, irq}, 8'h01);
      step(1);
      status_rd = 1'b1;
      step(1);
      status_rd = 1'b0;

      // R4: short pulse seen by at most one tick
      tick_mode = 2;
      step(12);
      dsr_n = 1'b0;
      step(2);
      dsr_n = 1'b1;
      step(16);
      @(negedge clk);
      chk("R4 glitch rejected", {6'h0, status_q[5], status_q[1]}, 8'h00);

      // R6: both directions flag on carrier detect
      step(1);
      dcd_n = 1'b0;
      step(20);
      @(negedge clk);
      chk("R6 carrier change flag", {6'h0, status_q[7], status_q[3]}, 8'h03);

      // Random phase against the model
      tick_mode = 3;
      for (int c = 0; c < 4000; c++) begin
         step(1);
         if (($urandom % 9) == 0) cts_n = ~cts_n;
         if (($urandom % 11) == 0) dsr_n = ~dsr_n;
         if (($urandom % 13) == 0) dcd_n = ~dcd_n;
         if (($urandom % 10) == 0) ri_n = ~ri_n;
         status_rd = ($urandom % 6) == 0;
      end
      status_rd = 1'b0;
      step(4);
      finish_run();
   end
endmodule